// File: doc/BRIEF.md
# Integer Multiply/Divide Unit with Result Interlock

This block is the multiply/divide side unit of a 32-bit integer pipeline. It accepts one of four commands: signed or unsigned multiply, signed or unsigned divide. For a multiply it forms the 64-bit product, with the upper word placed in HI and the lower word in LO. For a divide it forms the quotient in LO and the remainder in HI. Division by zero and the one signed overflow case do not trap. Each of them yields a fixed result.

The result registers are written when the command is accepted. A busy counter is loaded at the same time with the operation's modelled latency. It then counts down by one every cycle. The pipeline asks for HI or LO through a read port. While the counter is nonzero the unit raises `stall`, and the pipeline holds the read. Once the counter reaches zero, `rd_valid` rises with the register contents. Direct moves into HI or LO are accepted at any time, are never stalled, and leave the counter alone.

Multiply latency depends on how many significant bits the first operand has. Divide latency is a fixed figure. A command issued while the unit is busy replaces the results and reloads the counter.

Top module: `muldiv_unit`

## Requirements
- R1: During and directly after a synchronous active-low reset, HI and LO are zero, the busy count is zero, and a read is answered with `rd_valid` high and `stall` low in the same cycle.
- R2: Signed multiply (`cmd_op` = 2'b00) writes bits 63..32 of the two's-complement product of `cmd_rs` and `cmd_rt` to HI and bits 31..0 to LO.
- R3: Unsigned multiply (`cmd_op` = 2'b01) writes the upper and lower words of the unsigned 64-bit product to HI and LO.
- R4: The busy count loaded by a multiply is 7 + 4*(2 - floor(z/11)), where z is the count of leading zeros of (s | 1). For unsigned multiply, s is `cmd_rs`. The count is therefore 7, 11 or 15.
- R5: For signed multiply, s is `cmd_rs` XOR (`cmd_rs` shifted right arithmetically by 21). A negative operand is therefore sized by its magnitude.
- R6: Signed divide (`cmd_op` = 2'b10) and unsigned divide (`cmd_op` = 2'b11) both load a busy count of 37.
- R7: A divide with a nonzero divisor places the quotient in LO and the remainder in HI. A signed quotient truncates toward zero, and a signed remainder carries the sign of the dividend.
- R8: Division by zero sets HI to the dividend. LO becomes 0xFFFFFFFF for unsigned divide and for signed divide with a non-negative dividend. LO becomes 1 for signed divide with a negative dividend.
- R9: Signed 0x80000000 divided by 0xFFFFFFFF gives LO = 0x80000000 and HI = 0.
- R10: While `rd_req` is high and the busy count is nonzero, `stall` is high and `rd_valid` is low. The count drops by one each cycle. After exactly the loaded number of cycles, `rd_valid` rises and `rd_data` shows HI when `rd_sel` = 1 and LO when `rd_sel` = 0.
- R11: `mt_hi_we` or `mt_lo_we` writes `mt_data` into that register on the next clock, whether the unit is busy or not. The move neither stalls nor changes the busy count. When a command is accepted in the same cycle, the command's result wins.
- R12: A command accepted while the busy count is nonzero reloads the count with the new operation's latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| cmd_valid | input | 1 | Accept a multiply/divide command this cycle |
| cmd_op | input | 2 | 00 signed mul, 01 unsigned mul, 10 signed div, 11 unsigned div |
| cmd_rs | input | 32 | First operand (multiplicand / dividend) |
| cmd_rt | input | 32 | Second operand (multiplier / divisor) |
| mt_hi_we | input | 1 | Write `mt_data` into HI |
| mt_lo_we | input | 1 | Write `mt_data` into LO |
| mt_data | input | 32 | Data for direct moves |
| rd_req | input | 1 | Request to read HI or LO |
| rd_sel | input | 1 | 1 selects HI, 0 selects LO |
| rd_data | output | 32 | Selected register, meaningful with `rd_valid` |
| rd_valid | output | 1 | Read answered this cycle |
| stall | output | 1 | Read must be held, result not ready |

## Verification
The checker watches the counter's behaviour on every cycle. It confirms the load value after each command, covering the fixed divide figure and the three legal multiply figures. It also checks that the counter drops by one per idle cycle, that stall is released once the count runs out, that direct moves land on the next clock, and that HI and LO hold steady when nothing writes them. Only the bench's scenarios can show whether the arithmetic and the corner-case results are right, and whether the chosen multiply latency matches the operand size. The bench does this by sweeping every pair from an operand set rich in boundary values through all four commands and measuring the stall length of each read.

// File: rtl/muldiv_pkg.sv
// Package: shared operation encoding for the multiply/divide unit.
// Assumes the opcode field is two bits, with bit 1 separating divide
// from multiply and bit 0 selecting unsigned operation.
package muldiv_pkg;

    typedef enum logic [1:0] {
        MD_MUL_S = 2'b00,
        MD_MUL_U = 2'b01,
        MD_DIV_S = 2'b10,
        MD_DIV_U = 2'b11
    } md_op_e;

    // Bit 1 of the opcode set means divide.
    function automatic logic op_is_div(input md_op_e op);
        return op[1];
    endfunction

    // Bit 0 of the opcode clear means signed operation.
    function automatic logic op_is_signed(input md_op_e op);
        return ~op[0];
    endfunction

endpackage

// File: rtl/mdu_lat_calc.sv
// Module: mdu_lat_calc
// Computes the busy-count value loaded when a command is accepted.
// Multiply latency follows the leading-zero count of the first operand,
// grouped into buckets of LZ_BUCKET; signed operands are first folded
// by XOR with their arithmetic right shift so that magnitude decides.
// Divide latency is the constant DIV_LAT. Purely combinational.
module mdu_lat_calc #(
    parameter int XLEN       = 32,
    parameter int CNT_W      = 6,
    parameter int MUL_BASE   = 7,
    parameter int MUL_STEP   = 4,
    parameter int LZ_BUCKET  = 11,
    parameter int SIGN_SHIFT = 21,
    parameter int DIV_LAT    = 37
) (
    input  logic                is_div,
    input  logic                is_signed,
    input  logic [XLEN-1:0]     opa,
    output logic [CNT_W-1:0]    lat
);

    localparam int MAX_BUCKET = (XLEN - 1) / LZ_BUCKET;
    localparam int LZ_W       = $clog2(XLEN + 1);

    logic [XLEN-1:0] folded;
    logic [XLEN-1:0] probe;
    logic [LZ_W-1:0] lz;
    logic            seen_one;
    int              bucket;

    // Fold a signed operand so that leading sign copies count as zeros.
    always_comb begin
        if (is_signed) begin
            folded = opa ^ XLEN'($signed(opa) >>> SIGN_SHIFT);
        end else begin
            folded = opa;
        end
        probe = folded | XLEN'(1);
    end

    // Count leading zeros of the probe word, scanning from the top bit.
    always_comb begin
        lz       = '0;
        seen_one = 1'b0;
        for (int i = XLEN - 1; i >= 0; i--) begin
            if (!seen_one) begin
                if (probe[i]) begin
                    seen_one = 1'b1;
                end else begin
                    lz = lz + LZ_W'(1);
                end
            end
        end
    end

    // Map the leading-zero bucket (or divide) onto the cycle count.
    always_comb begin
        bucket = int'(lz) / LZ_BUCKET;
        if (bucket > MAX_BUCKET) begin
            bucket = MAX_BUCKET;
        end
        if (is_div) begin
            lat = CNT_W'(DIV_LAT);
        end else begin
            lat = CNT_W'(MUL_BASE + MUL_STEP * (MAX_BUCKET - bucket));
        end
    end

endmodule

// File: rtl/mdu_mul.sv
// Module: mdu_mul
// Full-width multiplier giving a 2*XLEN product for signed or unsigned
// operands. Both operands are widened by one bit (sign or zero) so a
// single signed multiply serves both modes. Purely combinational.
module mdu_mul #(
    parameter int XLEN = 32
) (
    input  logic                is_signed,
    input  logic [XLEN-1:0]     opa,
    input  logic [XLEN-1:0]     opb,
    output logic [XLEN-1:0]     prod_hi,
    output logic [XLEN-1:0]     prod_lo
);

    logic signed [XLEN:0]     a_ext;
    logic signed [XLEN:0]     b_ext;
    logic signed [2*XLEN+1:0] prod_full;

    // Widen each operand by its sign bit or by zero, per mode.
    always_comb begin
        a_ext = {is_signed & opa[XLEN-1], opa};
        b_ext = {is_signed & opb[XLEN-1], opb};
    end

    // Form the product and split it into the two result words.
    always_comb begin
        prod_full = a_ext * b_ext;
        prod_hi   = prod_full[2*XLEN-1:XLEN];
        prod_lo   = prod_full[XLEN-1:0];
    end

endmodule

// File: rtl/mdu_div.sv
// Module: mdu_div
// Signed/unsigned divider producing quotient and remainder with defined
// results for a zero divisor and for the most-negative / minus-one case.
// Signed division works on magnitudes and restores signs afterwards:
// the quotient truncates toward zero, and the remainder follows the
// dividend's sign. Purely combinational.
module mdu_div #(
    parameter int XLEN = 32
) (
    input  logic                is_signed,
    input  logic [XLEN-1:0]     dividend,
    input  logic [XLEN-1:0]     divisor,
    output logic [XLEN-1:0]     quot,
    output logic [XLEN-1:0]     rem
);

    localparam logic [XLEN-1:0] MOST_NEG = {1'b1, {(XLEN-1){1'b0}}};
    localparam logic [XLEN-1:0] ALL_ONES = {XLEN{1'b1}};

    logic            neg_a;
    logic            neg_b;
    logic [XLEN-1:0] mag_a;
    logic [XLEN-1:0] mag_b;
    logic [XLEN-1:0] uq;
    logic [XLEN-1:0] ur;
    logic            div_zero;
    logic            sgn_ovf;

    // Take operand magnitudes and classify the special cases.
    always_comb begin
        neg_a    = is_signed & dividend[XLEN-1];
        neg_b    = is_signed & divisor[XLEN-1];
        mag_a    = neg_a ? (~dividend + XLEN'(1)) : dividend;
        mag_b    = neg_b ? (~divisor + XLEN'(1)) : divisor;
        div_zero = (divisor == '0);
        sgn_ovf  = is_signed && (dividend == MOST_NEG) && (divisor == ALL_ONES);
    end

    // Unsigned core division, guarded against a zero divisor.
    always_comb begin
        if (div_zero) begin
            uq = '0;
            ur = '0;
        end else begin
            uq = mag_a / mag_b;
            ur = mag_a % mag_b;
        end
    end

    // Select the defined special result or re-sign the core result.
    always_comb begin
        if (div_zero) begin
            rem  = dividend;
            quot = neg_a ? XLEN'(1) : ALL_ONES;
        end else if (sgn_ovf) begin
            rem  = '0;
            quot = MOST_NEG;
        end else begin
            quot = (neg_a ^ neg_b) ? (~uq + XLEN'(1)) : uq;
            rem  = neg_a ? (~ur + XLEN'(1)) : ur;
        end
    end

endmodule

// File: rtl/muldiv_unit.sv
// Module: muldiv_unit (top)
// Multiply/divide unit with HI/LO result registers and a read interlock.
// Results are written at command acceptance; a busy counter models the
// operation latency and holds off reads until it expires. Direct moves
// into HI/LO bypass the interlock. Assumes a single command per cycle,
// and that the pipeline keeps rd_req asserted while stall is high.
// Reset is synchronous and active low.
module muldiv_unit #(
    parameter int XLEN       = 32,
    parameter int MUL_BASE   = 7,
    parameter int MUL_STEP   = 4,
    parameter int LZ_BUCKET  = 11,
    parameter int SIGN_SHIFT = 21,
    parameter int DIV_LAT    = 37
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  logic [1:0]       cmd_op,
    input  logic [XLEN-1:0]  cmd_rs,
    input  logic [XLEN-1:0]  cmd_rt,
    input  logic             mt_hi_we,
    input  logic             mt_lo_we,
    input  logic [XLEN-1:0]  mt_data,
    input  logic             rd_req,
    input  logic             rd_sel,
    output logic [XLEN-1:0]  rd_data,
    output logic             rd_valid,
    output logic             stall
);

    import muldiv_pkg::*;

    localparam int MUL_MAX = MUL_BASE + MUL_STEP * ((XLEN - 1) / LZ_BUCKET);
    localparam int LAT_MAX = (MUL_MAX > DIV_LAT) ? MUL_MAX : DIV_LAT;
    localparam int CNT_W   = $clog2(LAT_MAX + 1);

    md_op_e            op;
    logic              is_div;
    logic              is_signed;
    logic [CNT_W-1:0]  new_lat;
    logic [XLEN-1:0]   mul_hi;
    logic [XLEN-1:0]   mul_lo;
    logic [XLEN-1:0]   div_q;
    logic [XLEN-1:0]   div_r;
    logic [XLEN-1:0]   res_hi;
    logic [XLEN-1:0]   res_lo;
    logic [XLEN-1:0]   hi_q;
    logic [XLEN-1:0]   lo_q;
    logic [CNT_W-1:0]  busy_cnt;
    logic              busy;

    // Decode the command opcode into its mode bits.
    always_comb begin
        op        = md_op_e'(cmd_op);
        is_div    = op_is_div(op);
        is_signed = op_is_signed(op);
    end

    mdu_lat_calc #(
        .XLEN      (XLEN),
        .CNT_W     (CNT_W),
        .MUL_BASE  (MUL_BASE),
        .MUL_STEP  (MUL_STEP),
        .LZ_BUCKET (LZ_BUCKET),
        .SIGN_SHIFT(SIGN_SHIFT),
        .DIV_LAT   (DIV_LAT)
    ) u_lat (
        .is_div   (is_div),
        .is_signed(is_signed),
        .opa      (cmd_rs),
        .lat      (new_lat)
    );

    mdu_mul #(
        .XLEN(XLEN)
    ) u_mul (
        .is_signed(is_signed),
        .opa      (cmd_rs),
        .opb      (cmd_rt),
        .prod_hi  (mul_hi),
        .prod_lo  (mul_lo)
    );

    mdu_div #(
        .XLEN(XLEN)
    ) u_div (
        .is_signed(is_signed),
        .dividend (cmd_rs),
        .divisor  (cmd_rt),
        .quot     (div_q),
        .rem      (div_r)
    );

    // Route the selected unit's outputs to the HI/LO write values.
    always_comb begin
        res_hi = is_div ? div_r : mul_hi;
        res_lo = is_div ? div_q : mul_lo;
    end

    // HI/LO update: direct moves first, an accepted command overrides.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_q <= '0;
            lo_q <= '0;
        end else if (cmd_valid) begin
            hi_q <= res_hi;
            lo_q <= res_lo;
        end else begin
            if (mt_hi_we) begin
                hi_q <= mt_data;
            end
            if (mt_lo_we) begin
                lo_q <= mt_data;
            end
        end
    end

    // Busy counter: load on command, otherwise count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_cnt <= '0;
        end else if (cmd_valid) begin
            busy_cnt <= new_lat;
        end else if (busy_cnt != '0) begin
            busy_cnt <= busy_cnt - CNT_W'(1);
        end
    end

    // Read port: interlock against the counter and select HI or LO.
    always_comb begin
        busy     = (busy_cnt != '0);
        stall    = rd_req & busy;
        rd_valid = rd_req & ~busy;
        rd_data  = rd_sel ? hi_q : lo_q;
    end

endmodule

// File: rtl/muldiv_unit_chk.sv
// Module: muldiv_unit_chk
// Property checker bound into muldiv_unit. Observes the ports together with
// the HI/LO registers and the busy counter, and checks counter loading,
// countdown, stall release and register update rules.
module muldiv_unit_chk #(
    parameter int XLEN     = 32,
    parameter int CNT_W    = 6,
    parameter int MUL_BASE = 7,
    parameter int MUL_STEP = 4,
    parameter int MUL_MAX  = 15,
    parameter int DIV_LAT  = 37
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cmd_valid,
    input logic [1:0]       cmd_op,
    input logic             mt_hi_we,
    input logic             mt_lo_we,
    input logic [XLEN-1:0]  mt_data,
    input logic             rd_req,
    input logic             stall,
    input logic [XLEN-1:0]  hi_q,
    input logic [XLEN-1:0]  lo_q,
    input logic [CNT_W-1:0] busy_cnt
);

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (busy_cnt == '0 && hi_q == '0 && lo_q == '0));

    // R6
    div_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op[1]) |=> (busy_cnt == CNT_W'(DIV_LAT)));

    // R4
    mul_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_op[1]) |=>
            (busy_cnt >= CNT_W'(MUL_BASE) && busy_cnt <= CNT_W'(MUL_MAX) &&
             ((int'(busy_cnt) - MUL_BASE) % MUL_STEP) == 0));

    // R10
    countdown_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmd_valid && busy_cnt != '0) |=> (busy_cnt == $past(busy_cnt) - CNT_W'(1)));

    // R10
    stall_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && busy_cnt == CNT_W'(1) && !cmd_valid) |=> !stall);

    // R11
    move_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mt_hi_we && !cmd_valid) |=> (hi_q == $past(mt_data)));

    // R11
    move_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mt_lo_we && !cmd_valid) |=> (lo_q == $past(mt_data)));

    // R11
    hold_regs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmd_valid && !mt_hi_we && !mt_lo_we) |=> ($stable(hi_q) && $stable(lo_q)));

endmodule

bind muldiv_unit muldiv_unit_chk #(
    .XLEN    (XLEN),
    .CNT_W   (CNT_W),
    .MUL_BASE(MUL_BASE),
    .MUL_STEP(MUL_STEP),
    .MUL_MAX (MUL_MAX),
    .DIV_LAT (DIV_LAT)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmd_valid(cmd_valid),
    .cmd_op   (cmd_op),
    .mt_hi_we (mt_hi_we),
    .mt_lo_we (mt_lo_we),
    .mt_data  (mt_data),
    .rd_req   (rd_req),
    .stall    (stall),
    .hi_q     (hi_q),
    .lo_q     (lo_q),
    .busy_cnt (busy_cnt)
);

// File: tb/muldiv_unit_bench.sv
// Bench: sweeps all four commands over every pair drawn from a set of
// boundary operands, measures the stall length of each read and compares
// HI/LO with values computed arithmetically here, then runs directed
// cases for moves, restart and same-cycle priority.
module muldiv_unit_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [1:0]  cmd_op = 2'b00;
    logic [31:0] cmd_rs = '0;
    logic [31:0] cmd_rt = '0;
    logic        mt_hi_we = 1'b0;
    logic        mt_lo_we = 1'b0;
    logic [31:0] mt_data = '0;
    logic        rd_req = 1'b0;
    logic        rd_sel = 1'b0;
    logic [31:0] rd_data;
    logic        rd_valid;
    logic        stall;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2 clk = ~clk;

    muldiv_unit u_muldiv_unit (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_rs(cmd_rs), .cmd_rt(cmd_rt), .mt_hi_we(mt_hi_we),
        .mt_lo_we(mt_lo_we), .mt_data(mt_data), .rd_req(rd_req),
        .rd_sel(rd_sel), .rd_data(rd_data), .rd_valid(rd_valid), .stall(stall)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic int clz32(input logic [31:0] v);
        for (int i = 31; i >= 0; i--) if (v[i]) return 31 - i;
        return 32;
    endfunction

    // Hold rd_req and count stalled cycles; leaves the bench 1ns past a negedge.
    task automatic count_stall(output int n);
        n = 0;
        #1;
        while (stall && n < 200) begin
            n++;
            @(negedge clk);
            #1;
        end
    endtask

    task automatic run_vec(input logic [1:0] op, input logic [31:0] a, input logic [31:0] b);
        logic [31:0] ehi, elo, fold;
        logic [63:0] p;
        int elat, n;
        string tag;
        if (!op[1]) begin
            fold = op[0] ? a : (a ^ 32'($signed(a) >>> 21));
            elat = 7 + 4 * (2 - clz32(fold | 32'd1) / 11);
            p    = op[0] ? (64'(a) * 64'(b)) : 64'(longint'($signed(a)) * longint'($signed(b)));
            ehi  = p[63:32];
            elo  = p[31:0];
            tag  = op[0] ? "R3" : "R2";
        end else begin
            elat = 37;
            if (b == 0) begin
                ehi = a;
                elo = (!op[0] && a[31]) ? 32'd1 : 32'hFFFFFFFF;
                tag = "R8";
            end else if (!op[0] && a == 32'h80000000 && b == 32'hFFFFFFFF) begin
                ehi = 0; elo = 32'h80000000; tag = "R9";
            end else if (op[0]) begin
                elo = a / b; ehi = a % b; tag = "R7";
            end else begin
                elo = 32'($signed(a) / $signed(b));
                ehi = 32'($signed(a) % $signed(b));
                tag = "R7";
            end
        end
        @(negedge clk);
        cmd_valid = 1; cmd_op = op; cmd_rs = a; cmd_rt = b;
        @(negedge clk);
        cmd_valid = 0; rd_req = 1; rd_sel = 0;
        count_stall(n);
        check(op[1] ? "R6 latency" : (op[0] ? "R4 latency" : "R5 latency"), 32'(n), 32'(elat));
        check({tag, " LO R10"}, {rd_valid, rd_data[30:0]} ^ {1'b1, 31'b0} ^ {rd_data[31], 31'b0}, elo);
        rd_sel = 1; #1;
        check({tag, " HI"}, rd_data, ehi);
        rd_req = 0;
    endtask

    logic [31:0] vals [12] = '{32'h0, 32'h1, 32'h2, 32'h7, 32'h7FFFFFFF, 32'h80000000,
                               32'hFFFFFFFF, 32'hFFFFFFFE, 32'h12345678, 32'hFEDCBA98,
                               32'h00000400, 32'h00200000};

    initial begin
        int n;
        repeat (3) @(negedge clk);
        rst_n = 1;
        rd_req = 1; rd_sel = 0; #1;
        // R1: reset state answered at once with zeros
        check("R1 stall", 32'(stall), 0);
        check("R1 valid", 32'(rd_valid), 1);
        check("R1 LO", rd_data, 0);
        rd_sel = 1; #1;
        check("R1 HI", rd_data, 0);
        rd_req = 0;

        for (int op = 0; op < 4; op++)
            for (int i = 0; i < 12; i++)
                for (int j = 0; j < 12; j++)
                    run_vec(2'(op), vals[i], vals[j]);

        // R11: move while idle lands next clock without stall
        @(negedge clk);
        mt_lo_we = 1; mt_data = 32'hCAFE0001;
        @(negedge clk);
        mt_lo_we = 0; rd_req = 1; rd_sel = 0; #1;
        check("R11 idle stall", 32'(stall), 0);
        check("R11 idle LO", rd_data, 32'hCAFE0001);
        rd_req = 0;

        // R11: move to HI while a divide is busy; count unaffected
        @(negedge clk);
        cmd_valid = 1; cmd_op = 2'b11; cmd_rs = 100; cmd_rt = 7;
        @(negedge clk);
        cmd_valid = 0; mt_hi_we = 1; mt_data = 32'hDEADBEEF; rd_req = 1; rd_sel = 1;
        #1;
        check("R11 busy stall", 32'(stall), 1);
        @(negedge clk);
        mt_hi_we = 0;
        count_stall(n);
        check("R11 count kept", 32'(n), 36);
        check("R11 HI moved", rd_data, 32'hDEADBEEF);
        rd_sel = 0; #1;
        check("R11 LO kept", rd_data, 32'd14);
        rd_req = 0;

        // R12: a divide issued while a multiply is pending reloads the count
        @(negedge clk);
        cmd_valid = 1; cmd_op = 2'b01; cmd_rs = 1; cmd_rt = 9;
        @(negedge clk);
        cmd_valid = 0;
        repeat (3) @(negedge clk);
        cmd_valid = 1; cmd_op = 2'b10; cmd_rs = 32'hFFFFFFF9; cmd_rt = 2;
        @(negedge clk);
        cmd_valid = 0; rd_req = 1; rd_sel = 0;
        count_stall(n);
        check("R12 restart", 32'(n), 37);
        check("R12 LO", rd_data, 32'hFFFFFFFD);
        rd_req = 0;

        // R11: command wins over a same-cycle move
        @(negedge clk);
        cmd_valid = 1; cmd_op = 2'b00; cmd_rs = 3; cmd_rt = 5;
        mt_lo_we = 1; mt_hi_we = 1; mt_data = 32'hAAAA5555;
        @(negedge clk);
        cmd_valid = 0; mt_lo_we = 0; mt_hi_we = 0; rd_req = 1; rd_sel = 0;
        count_stall(n);
        check("R11 priority LO", rd_data, 32'd15);
        rd_sel = 1; #1;
        check("R11 priority HI", rd_data, 32'd0);
        rd_req = 0;

        done = 1;
    end

    initial begin
        for (int c = 0; c < 200000 && !done; c++) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
        end
        $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule